// File: doc/BRIEF.md
# Float to Signed Fixed-Point Converter

This block takes one floating-point operand, which can be half, single or double precision. It multiplies the operand by a power of two that the caller chooses, cuts the result toward zero and writes it as a signed two's-complement fixed-point word of 32 or 64 bits. The caller picks the number of fractional bits for each conversion. The block handles every operand class: normal, subnormal, both zeros, both infinities and NaN. It also handles results that fall outside the chosen width.

A conversion starts when `inValid` is high for one clock. The result, the two exception outputs and `outValid` appear together on the next clock. There are two exceptions, invalid and inexact. Each one has an enable bit in `trapEn`. When an exception is raised and its enable bit is set, the block asks for a trap through `trapReq`. When its enable bit is clear, the block sets the matching sticky status bit instead. A sticky bit stays set until reset.

Top module: `fxConvert`

## Requirements
- R1: `srcFmt` selects the source format: 0 is half, 1 is single, 2 is double. `dstWide` selects the destination width: 0 is 32 bits, 1 is 64 bits. All six pairs convert. `srcFmt` = 3 is an invalid request: the result is 0 and invalid is raised.
- R2: The result is the operand value times 2^`fracBits`, truncated toward zero, in two's complement. A 32-bit result sits in `result[31:0]` and `result[63:32]` is zero.
- R3: `fracBits` must be 1 to 32 for a 32-bit destination and 1 to 64 for a 64-bit destination. Any other value gives result 0 with invalid raised.
- R4: A NaN operand gives result 0 and raises invalid.
- R5: A scaled value outside the signed range of the destination saturates to the most positive or most negative value and raises invalid. Infinities behave the same way. The most negative value itself converts exactly. Inexact is never raised together with invalid.
- R6: Inexact is raised when nonzero bits are discarded and the result does not saturate. This includes subnormals that truncate to zero.
- R7: Positive and negative zero give result 0 with no exception.
- R8: Result, exceptions and `outValid` appear one clock after `inValid`. When `inValid` is low, `outValid` is low and the result holds its value.
- R9: `trapEn[0]` controls invalid and `trapEn[1]` controls inexact. When a raised exception is enabled, `trapReq` goes high and no sticky bit is set. When it is disabled, the block sets `stickyFlags[0]` for invalid or `stickyFlags[1]` for inexact. Sticky bits are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Starts a conversion |
| operand | input | 64 | Raw floating-point bits; narrow formats sit in the low bits |
| srcFmt | input | 2 | Source format select |
| dstWide | input | 1 | Destination width select |
| fracBits | input | 7 | Fractional-bit count |
| trapEn | input | 2 | Trap enable per exception |
| outValid | output | 1 | Result valid |
| result | output | 64 | Fixed-point result |
| excInvalid | output | 1 | Invalid raised by this conversion |
| excInexact | output | 1 | Inexact raised by this conversion |
| trapReq | output | 1 | An enabled exception was raised |
| stickyFlags | output | 2 | Accumulated untrapped exceptions |

## Verification
The hardest cases sit right at the edge of the destination range. One is a value of exactly minus 2^(W-1), which must convert without error, next to plus 2^(W-1), which must saturate. The other is a subnormal that truncates to zero yet still has to raise inexact. Random operands rarely land in either spot, because a random exponent usually saturates or truncates far from the boundary. The random generator therefore keeps exponents within a narrow window around the bias. Directed vectors then place the scaled value exactly on plus and minus 2^31 and on the smallest single-precision subnormal.

// File: rtl/fxPkg.sv
package fxPkg;
  typedef enum logic [1:0] {
    FMT_HALF   = 2'd0,
    FMT_SINGLE = 2'd1,
    FMT_DOUBLE = 2'd2,
    FMT_RSVD   = 2'd3
  } srcFmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic badReq;
    logic isNan;
    logic isInf;
    logic isZero;
  } convStrobe_t;
endpackage

// File: rtl/fxCtrl.sv
module fxCtrl
  import fxPkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int NARROW_W = 32,
  parameter int FB_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [62:0]       opBits,
  input  logic [1:0]        srcFmt,
  input  logic              dstWide,
  input  logic [FB_W-1:0]   fracBits,
  input  logic [1:0]        trapEn,
  input  logic              dpOvf,
  input  logic              dpLost,
  output convStrobe_t       strobe,
  output logic              outValid,
  output logic              excInvalid,
  output logic              excInexact,
  output logic              trapReq,
  output logic [1:0]        stickyFlags
);
  logic expOnes, expZero, fracNz;
  logic [FB_W:0] fbLimit;
  logic raiseInv, raiseInx;

  always_comb begin
    unique case (srcFmt)
      FMT_HALF: begin
        expOnes = &opBits[14:10];
        expZero = ~|opBits[14:10];
        fracNz  = |opBits[9:0];
      end
      FMT_SINGLE: begin
        expOnes = &opBits[30:23];
        expZero = ~|opBits[30:23];
        fracNz  = |opBits[22:0];
      end
      default: begin
        expOnes = &opBits[62:52];
        expZero = ~|opBits[62:52];
        fracNz  = |opBits[51:0];
      end
    endcase
  end

  assign fbLimit = dstWide ? (FB_W+1)'(WORD_W) : (FB_W+1)'(NARROW_W);

  always_comb begin
    strobe.load   = inValid;
    strobe.badReq = (srcFmt == FMT_RSVD) || (fracBits == '0) ||
                    ({1'b0, fracBits} > fbLimit);
    strobe.isNan  = expOnes & fracNz;
    strobe.isInf  = expOnes & ~fracNz;
    strobe.isZero = expZero & ~fracNz;
  end

  assign raiseInv = strobe.badReq | strobe.isNan | strobe.isInf | dpOvf;
  assign raiseInx = ~raiseInv & dpLost;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      excInvalid  <= 1'b0;
      excInexact  <= 1'b0;
      trapReq     <= 1'b0;
      stickyFlags <= 2'b00;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        excInvalid  <= raiseInv;
        excInexact  <= raiseInx;
        trapReq     <= (raiseInv & trapEn[0]) | (raiseInx & trapEn[1]);
        stickyFlags <= stickyFlags |
                       {raiseInx & ~trapEn[1], raiseInv & ~trapEn[0]};
      end
    end
  end

  assert_flag_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(excInvalid && excInexact));
  assert_trap_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (excInvalid || excInexact));
  assert_sticky_keep_R9: assert property (@(posedge clk) disable iff (!rstN)
    (($past(stickyFlags) & ~stickyFlags) == 2'b00));
endmodule

// File: rtl/fxDatapath.sv
module fxDatapath
  import fxPkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int NARROW_W = 32,
  parameter int FB_W     = 7,
  parameter int SIG_W    = 53
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] operand,
  input  logic [1:0]        srcFmt,
  input  logic              dstWide,
  input  logic [FB_W-1:0]   fracBits,
  input  convStrobe_t       strobe,
  output logic              dpOvf,
  output logic              dpLost,
  output logic [WORD_W-1:0] result
);
  localparam int MAG_W = 2 * WORD_W;

  logic              sign, hid;
  int                unb, sh;
  logic [SIG_W-1:0]  sig;
  logic [MAG_W-1:0]  mag, lim;
  logic              big;
  logic [WORD_W-1:0] mag64, signedVal, fitVal, satVal, nextRes;
  logic [6:0]        shAmt;

  // unpack into a common significand with the leading bit at SIG_W-1
  always_comb begin
    unique case (srcFmt)
      FMT_HALF: begin
        sign = operand[15];
        hid  = |operand[14:10];
        unb  = hid ? int'(operand[14:10]) - 15 : -14;
        sig  = {hid, operand[9:0], 42'b0};
      end
      FMT_SINGLE: begin
        sign = operand[31];
        hid  = |operand[30:23];
        unb  = hid ? int'(operand[30:23]) - 127 : -126;
        sig  = {hid, operand[22:0], 29'b0};
      end
      default: begin
        sign = operand[63];
        hid  = |operand[62:52];
        unb  = hid ? int'(operand[62:52]) - 1023 : -1022;
        sig  = {hid, operand[51:0]};
      end
    endcase
  end

  // scale by 2^fracBits and truncate
  always_comb begin
    sh     = unb - (SIG_W - 1) + int'(fracBits);
    shAmt  = sh[6:0];
    big    = 1'b0;
    dpLost = 1'b0;
    mag    = '0;
    if (sh >= WORD_W) begin
      big = |sig;
    end else if (sh >= 0) begin
      mag = {{(MAG_W-SIG_W){1'b0}}, sig} << shAmt;
    end else if (sh > -WORD_W) begin
      shAmt  = 7'(-sh);
      mag    = {{(MAG_W-SIG_W){1'b0}}, sig >> shAmt};
      dpLost = |({{(WORD_W-SIG_W){1'b0}}, sig} &
                 ((WORD_W'(1) << shAmt) - WORD_W'(1)));
    end else begin
      dpLost = |sig;
    end
  end

  assign lim   = dstWide ? (MAG_W'(1) << (WORD_W-1)) : (MAG_W'(1) << (NARROW_W-1));
  assign dpOvf = big | (sign ? (mag > lim) : (mag >= lim));

  assign mag64     = mag[WORD_W-1:0];
  assign signedVal = sign ? (~mag64 + WORD_W'(1)) : mag64;

  generate
    if (WORD_W > NARROW_W) begin : gNarrow
      assign fitVal = dstWide ? signedVal
                    : {{(WORD_W-NARROW_W){1'b0}}, signedVal[NARROW_W-1:0]};
      assign satVal = dstWide ? {sign, {(WORD_W-1){~sign}}}
                    : {{(WORD_W-NARROW_W){1'b0}}, sign, {(NARROW_W-1){~sign}}};
    end else begin : gSame
      assign fitVal = signedVal;
      assign satVal = {sign, {(WORD_W-1){~sign}}};
    end
  endgenerate

  always_comb begin
    if (strobe.badReq || strobe.isNan || strobe.isZero) nextRes = '0;
    else if (strobe.isInf || dpOvf)                     nextRes = satVal;
    else                                                nextRes = fitVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            result <= '0;
    else if (strobe.load) result <= nextRes;
  end

  assert_nan_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && (strobe.isNan || strobe.badReq)) |=> (result == '0));
  assert_narrow_upper_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !dstWide) |=> (result[WORD_W-1:NARROW_W] == '0));
endmodule

// File: rtl/fxConvert.sv
module fxConvert
  import fxPkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int NARROW_W = 32,
  parameter int FB_W     = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] operand,
  input  logic [1:0]        srcFmt,
  input  logic              dstWide,
  input  logic [FB_W-1:0]   fracBits,
  input  logic [1:0]        trapEn,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic              excInvalid,
  output logic              excInexact,
  output logic              trapReq,
  output logic [1:0]        stickyFlags
);
  convStrobe_t strobe;
  logic dpOvf, dpLost;

  fxCtrl #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .FB_W(FB_W)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opBits(operand[62:0]),
    .srcFmt(srcFmt), .dstWide(dstWide), .fracBits(fracBits), .trapEn(trapEn),
    .dpOvf(dpOvf), .dpLost(dpLost), .strobe(strobe), .outValid(outValid),
    .excInvalid(excInvalid), .excInexact(excInexact), .trapReq(trapReq),
    .stickyFlags(stickyFlags)
  );

  fxDatapath #(.WORD_W(WORD_W), .NARROW_W(NARROW_W), .FB_W(FB_W)) uData (
    .clk(clk), .rstN(rstN), .operand(operand), .srcFmt(srcFmt),
    .dstWide(dstWide), .fracBits(fracBits), .strobe(strobe),
    .dpOvf(dpOvf), .dpLost(dpLost), .result(result)
  );
endmodule

// File: tb/sim_fxConvert.sv
module sim_fxConvert;
  logic clk = 1'b0, rstN = 1'b0, inValid = 1'b0, dstWide = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  srcFmt = '0, trapEn = '0;
  logic [6:0]  fracBits = '0;
  logic outValid, excInvalid, excInexact, trapReq;
  logic [63:0] result;
  logic [1:0]  stickyFlags;
  int nChecks = 0, nFails = 0;
  logic [1:0] expSticky = '0;
  logic [63:0] lastRes = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  fxConvert u0 (.clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand),
    .srcFmt(srcFmt), .dstWide(dstWide), .fracBits(fracBits), .trapEn(trapEn),
    .outValid(outValid), .result(result), .excInvalid(excInvalid),
    .excInexact(excInexact), .trapReq(trapReq), .stickyFlags(stickyFlags));

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model built from the requirements with a wide integer
  task automatic refConv(input logic [63:0] op, input logic [1:0] fmt, input logic wide,
                         input logic [6:0] fb, output logic [63:0] res,
                         output logic inv, output logic inx);
    int ew, fw, bias, w, e2;
    logic [63:0] ex, fr, sg;
    logic s;
    logic [2303:0] big, ip, lim;
    ew = (fmt == 0) ? 5 : (fmt == 1) ? 8 : 11;
    fw = (fmt == 0) ? 10 : (fmt == 1) ? 23 : 52;
    bias = (1 << (ew - 1)) - 1;
    w = wide ? 64 : 32;
    ex = (op >> fw) & ((64'd1 << ew) - 1);
    fr = op & ((64'd1 << fw) - 1);
    s = op[fw + ew];
    res = '0; inv = 0; inx = 0;
    if (fmt == 3 || fb == 0 || int'(fb) > w) begin
      inv = 1;
    end else if (ex == ((64'd1 << ew) - 1)) begin
      inv = 1;
      if (fr == 0) res = s ? (64'd1 << (w - 1)) : ((64'd1 << (w - 1)) - 1);
    end else begin
      sg = (ex == 0) ? fr : (fr | (64'd1 << fw));
      e2 = ((ex == 0) ? 1 : int'(ex)) - bias - fw + int'(fb);
      big = 2304'(sg) << (e2 + 1200);
      ip = big >> 1200;
      lim = 2304'(1) << (w - 1);
      if (s ? (ip > lim) : (ip >= lim)) begin
        inv = 1;
        res = s ? (64'd1 << (w - 1)) : ((64'd1 << (w - 1)) - 1);
      end else begin
        res = s ? (~ip[63:0] + 64'd1) : ip[63:0];
        if (!wide) res = {32'b0, res[31:0]};
        inx = |big[1199:0];
      end
    end
  endtask

  task automatic runOp(string tag, logic [63:0] op, logic [1:0] fmt, logic wide,
                       logic [6:0] fb, logic [1:0] te);
    logic [63:0] eRes; logic eInv, eInx;
    refConv(op, fmt, wide, fb, eRes, eInv, eInx);
    @(negedge clk);
    operand = op; srcFmt = fmt; dstWide = wide; fracBits = fb; trapEn = te; inValid = 1;
    @(negedge clk);
    inValid = 0;
    expSticky = expSticky | {eInx & ~te[1], eInv & ~te[0]};
    check(tag, "result", result, eRes);
    check(tag, "invalid", 64'(excInvalid), 64'(eInv));
    check(tag, "inexact", 64'(excInexact), 64'(eInx));
    check("R8", "outValid", 64'(outValid), 64'd1);
    check("R9", "trapReq", 64'(trapReq), 64'((eInv & te[0]) | (eInx & te[1])));
    check("R9", "sticky", 64'(stickyFlags), 64'(expSticky));
    lastRes = result;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R8", "reset outValid", 64'(outValid), 64'd0);
    check("R8", "reset result", result, 64'd0);
    check("R9", "reset sticky", 64'(stickyFlags), 64'd0);

    runOp("R2", 64'h3FF0000000000000, 2, 0, 1, 0);   // 1.0 -> 2
    runOp("R6", 64'hBFFC000000000000, 2, 0, 1, 0);   // -1.75 -> -3, inexact
    runOp("R5", 64'hBFF0000000000000, 2, 0, 31, 0);  // exactly -2^31
    runOp("R5", 64'h3FF0000000000000, 2, 0, 31, 0);  // +2^31 saturates
    runOp("R5", 64'h00000000FF800000, 1, 1, 5, 0);   // -inf single to 64
    runOp("R4", 64'h0000000000007E00, 0, 0, 4, 0);   // half NaN
    runOp("R7", 64'h0000000000000000, 2, 1, 10, 0);  // +0
    runOp("R7", 64'h8000000000000000, 2, 1, 10, 0);  // -0
    runOp("R6", 64'h0000000000000001, 1, 0, 32, 0);  // subnormal -> 0 inexact
    runOp("R3", 64'h3FF0000000000000, 2, 0, 0, 0);
    runOp("R3", 64'h3FF0000000000000, 2, 0, 33, 0);
    runOp("R3", 64'h3FF0000000000000, 2, 1, 65, 0);
    runOp("R3", 64'hBE00000000000000, 2, 1, 64, 0);  // 64 legal on wide
    runOp("R1", 64'h3FF0000000000000, 3, 1, 8, 0);
    runOp("R1", 64'h000000000000BC00, 0, 1, 3, 0);   // half -1.0 to 64
    runOp("R9", 64'h0000000000007E00, 0, 0, 4, 2'b01);
    runOp("R9", 64'hBFFC000000000000, 2, 1, 1, 2'b10);

    // R8: idle cycle holds result
    @(negedge clk);
    operand = 64'h4000000000000000; srcFmt = 2; fracBits = 3;
    @(negedge clk);
    check("R8", "idle outValid", 64'(outValid), 64'd0);
    check("R8", "idle hold", result, lastRes);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] fmt; logic wide; logic [6:0] fb; logic [63:0] op;
      int ew, fw, bias, e;
      fmt = ($urandom % 16 == 0) ? 2'd3 : 2'($urandom % 3);
      wide = $urandom % 2;
      fb = ($urandom % 10 == 0) ? 7'($urandom) : 7'(1 + $urandom % (wide ? 64 : 32));
      ew = (fmt == 0) ? 5 : (fmt == 1) ? 8 : 11;
      fw = (fmt == 0) ? 10 : (fmt == 1) ? 23 : 52;
      bias = (1 << (ew - 1)) - 1;
      e = bias + int'($urandom % 90) - 70;
      if (fmt == 0) e = int'($urandom % 32);
      if (e < 0) e = 0;
      if (e > 2 * bias + 1) e = 2 * bias + 1;
      op = {$urandom, $urandom} & ((64'd1 << fw) - 1);
      op = op | (64'(e) << fw) | (64'($urandom % 2) << (fw + ew));
      runOp("R2", op, fmt, wide, fb, 2'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule